// File: doc/BRIEF.md
# Synchronized Stepper Step Timer

This block paces a scan stepper motor. Software programs a start-delay value, a step-interval value and a control word through a small write port. Setting the run bit arms a one-shot start delay. In sync mode the delay waits for the next scan-cycle start pulse before it starts counting. When the delay runs out, the block issues the first step pulse to a downstream phase sequencer. After that, a reloading interval counter issues one step pulse per interval. The interval register is double-buffered. Each time a step fires, the register is copied into the counter and a sticky interrupt is raised. Software then has a full interval to write the next value.

The controller has four states:
- `ST_IDLE`: stopped, counters at zero.
- `ST_WAIT`: armed, waiting for a scan-cycle start pulse.
- `ST_DELAY`: the one-shot delay counter is running.
- `ST_STEP`: the interval counter is reloading on every step.

The transitions are:
- IDLE→WAIT: run bit rises with sync mode set.
- IDLE→DELAY: run bit rises with sync mode clear.
- WAIT→DELAY: a sync pulse is sampled.
- DELAY→STEP: the delay expires.
- STEP→STEP: the interval counter expires.
- Any state→IDLE: the run bit is clear.

Write map, as a 2-bit address:
- 0: control word. Bit 0 is run and bit 1 is sync mode.
- 1: delay value.
- 2: interval value.
- 3: interrupt acknowledge. Writing 1 to bit 0 clears the interrupt.

Counters are W-bit down-counters clocked by the system clock. A programmed value of 0 counts as 1.

Top module: `sst_step_timer`

## Requirements
- R1: After reset, `step_pulse` and `step_irq` are 0, and no step occurs while the run bit is 0.
- R2: With sync mode clear, a control write that raises the run bit produces the first step pulse L+1 clock edges after the write edge, where L is the delay value.
- R3: With sync mode set, no step pulse and no interrupt occur until a scan-cycle start pulse is sampled. The first step pulse then appears L edges after the edge that sampled the sync pulse.
- R4: Each expiry produces a step pulse that is high for exactly one cycle.
- R5: The interval register is double-buffered. The value it holds at step k sets the spacing between step k and step k+1, so a write made after step k first affects the gap between steps k+1 and k+2.
- R6: `step_irq` is set together with every step pulse. It stays set until a write to address 3 with bit 0 set. A write to address 3 with bit 0 clear has no effect.
- R7: A scan-cycle start pulse arriving while stepping is already running changes no interval.
- R8: Clearing the run bit clears both counters and produces no later step pulse. Raising the run bit again restarts with the one-shot delay.
- R9: A delay or interval value of 0 is timed as 1 clock edge. An interval of 0 therefore yields a step pulse on consecutive cycles.
- R10: Writing the control word with the run bit already set does not restart or disturb the stepping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; counters tick on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 delay, 2 interval, 3 acknowledge) |
| wr_data | input | W | Write data |
| scan_sync | input | 1 | Scan-cycle start pulse, sampled on the clock |
| step_pulse | output | 1 | One-cycle step request to the phase sequencer |
| step_irq | output | 1 | Sticky step interrupt |

## Verification
A controller stuck in the wrong state shows up at the ports within one programmed interval. It appears as a step pulse that never comes, comes early, or keeps coming after the run bit is cleared. Bad counter reload timing shows up as a step-to-step spacing that is off by a clock, so spacings are measured in exact edge counts. Loss of double buffering shows up as the new interval taking effect one step too early. Wrong sync handling shows up either as a pulse during the wait or as a changed interval after a stray sync pulse.

// File: rtl/sst_pkg.sv
package sst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DELAY,
        ST_STEP
    } sst_state_e;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_DELAY = 2'd1;
    localparam logic [1:0] ADDR_STEP  = 2'd2;
    localparam logic [1:0] ADDR_ACK   = 2'd3;
endpackage

// File: rtl/sst_regs.sv
module sst_regs
    import sst_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic         run_en,
    output logic         sync_mode,
    output logic [W-1:0] delay_val,
    output logic [W-1:0] step_val,
    output logic         irq_ack
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en    <= 1'b0;
            sync_mode <= 1'b0;
            delay_val <= '0;
            step_val  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: begin
                    run_en    <= wr_data[0];
                    sync_mode <= wr_data[1];
                end
                ADDR_DELAY: delay_val <= wr_data;
                ADDR_STEP:  step_val  <= wr_data;
                default: ;
            endcase
        end
    end

    assign irq_ack = wr_en && (wr_addr == ADDR_ACK) && wr_data[0];
endmodule

// File: rtl/sst_timer.sv
module sst_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic [W-1:0] count,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    assign expire = run && !clr && (count == ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (load) begin
            count <= (load_val == '0) ? ONE : load_val;
        end else if (run && (count != '0)) begin
            count <= count - ONE;
        end
    end

    p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !clr && count != '0) |=> (count == $past(count) - ONE));
endmodule

// File: rtl/sst_step_timer.sv
module sst_step_timer
    import sst_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         scan_sync,
    output logic         step_pulse,
    output logic         step_irq
);
    logic         run_en, sync_mode, irq_ack, en_q, arm;
    logic [W-1:0] delay_val, step_val, dly_cnt, stp_cnt;
    logic         dly_load, stp_load, dly_exp, stp_exp, fire;
    sst_state_e   state_q, state_d;

    sst_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .run_en(run_en), .sync_mode(sync_mode),
        .delay_val(delay_val), .step_val(step_val), .irq_ack(irq_ack)
    );

    sst_timer #(.W(W)) u_delay (
        .clk(clk), .rst_n(rst_n), .clr(!run_en), .load(dly_load),
        .load_val(delay_val), .run(state_q == ST_DELAY),
        .count(dly_cnt), .expire(dly_exp)
    );

    sst_timer #(.W(W)) u_step (
        .clk(clk), .rst_n(rst_n), .clr(!run_en), .load(stp_load),
        .load_val(step_val), .run(state_q == ST_STEP),
        .count(stp_cnt), .expire(stp_exp)
    );

    assign arm = run_en && !en_q;

    always_comb begin
        state_d  = state_q;
        dly_load = 1'b0;
        stp_load = 1'b0;
        fire     = 1'b0;
        if (!run_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (arm) begin
                        if (sync_mode) begin
                            state_d = ST_WAIT;
                        end else begin
                            state_d  = ST_DELAY;
                            dly_load = 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (scan_sync) begin
                        state_d  = ST_DELAY;
                        dly_load = 1'b1;
                    end
                end
                ST_DELAY: begin
                    if (dly_exp) begin
                        state_d  = ST_STEP;
                        stp_load = 1'b1;
                        fire     = 1'b1;
                    end
                end
                ST_STEP: begin
                    if (stp_exp) begin
                        stp_load = 1'b1;
                        fire     = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= run_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_pulse <= 1'b0;
            step_irq   <= 1'b0;
        end else begin
            step_pulse <= fire;
            if (fire) begin
                step_irq <= 1'b1;
            end else if (irq_ack) begin
                step_irq <= 1'b0;
            end
        end
    end

    p_pulse_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |-> step_irq);

    p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step_irq) |-> $past(irq_ack));

    p_wait_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && $past(state_q) == ST_WAIT) |-> !step_pulse);

    p_off_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (dly_cnt == '0 && stp_cnt == '0));

    p_pulse_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |-> $past(run_en));
endmodule

// File: tb/tb_sst_step_timer.sv
`timescale 1ns/1ps
module tb_sst_step_timer;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         scan_sync = 1'b0;
    logic         step_pulse, step_irq;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    sst_step_timer #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .scan_sync(scan_sync),
        .step_pulse(step_pulse), .step_irq(step_irq)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input int d, output int t);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
        t = cyc;
    endtask

    task automatic sync_pulse(output int t);
        @(negedge clk);
        scan_sync = 1'b1;
        @(negedge clk);
        scan_sync = 1'b0;
        t = cyc;
    endtask

    task automatic wait_pulse(output int t);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!step_pulse && n < 2000);
        if (!step_pulse) check(1'b0, "timeout", 0, 1);
        t = cyc;
    endtask

    task automatic count_pulses(input int span, output int c);
        c = 0;
        for (int i = 0; i < span; i++) begin
            @(negedge clk);
            if (step_pulse) c++;
        end
    endtask

    task automatic test_reset();
        int c;
        check(step_pulse == 1'b0, "R1 pulse", step_pulse, 0);
        check(step_irq == 1'b0, "R1 irq", step_irq, 0);
        count_pulses(20, c);
        check(c == 0, "R1 idle pulses", c, 0);
    endtask

    task automatic test_free_run();
        int t, p1, p2, p3, p4, p5;
        cpu_write(2'd1, 5, t);
        cpu_write(2'd2, 4, t);
        cpu_write(2'd0, 1, t);
        wait_pulse(p1);
        check(p1 - t == 6, "R2 first delay", p1 - t, 6);
        check(step_irq == 1'b1, "R6 irq set", step_irq, 1);
        cpu_write(2'd2, 9, t);
        wait_pulse(p2);
        check(p2 - p1 == 4, "R5 old interval", p2 - p1, 4);
        wait_pulse(p3);
        check(p3 - p2 == 9, "R5 new interval", p3 - p2, 9);
        @(negedge clk);
        check(step_pulse == 1'b0, "R4 one cycle", step_pulse, 0);
        cpu_write(2'd3, 0, t);
        check(step_irq == 1'b1, "R6 zero ack ignored", step_irq, 1);
        cpu_write(2'd3, 1, t);
        check(step_irq == 1'b0, "R6 ack clears", step_irq, 0);
        sync_pulse(t);
        wait_pulse(p4);
        check(p4 - p3 == 9, "R7 sync ignored", p4 - p3, 9);
        cpu_write(2'd0, 1, t);
        wait_pulse(p5);
        check(p5 - p4 == 9, "R10 rewrite run", p5 - p4, 9);
    endtask

    task automatic test_disable_restart();
        int t, c, p1, p2;
        cpu_write(2'd0, 0, t);
        count_pulses(40, c);
        check(c == 0, "R8 no pulse after off", c, 0);
        cpu_write(2'd1, 0, t);
        cpu_write(2'd2, 3, t);
        cpu_write(2'd3, 1, t);
        cpu_write(2'd0, 1, t);
        wait_pulse(p1);
        check(p1 - t == 2, "R9 zero delay", p1 - t, 2);
        check(step_irq == 1'b1, "R8 restart irq", step_irq, 1);
        wait_pulse(p2);
        check(p2 - p1 == 3, "R8 restart interval", p2 - p1, 3);
        cpu_write(2'd0, 0, t);
    endtask

    task automatic test_sync_mode();
        int t, c, p1, p2, p3;
        cpu_write(2'd3, 1, t);
        cpu_write(2'd1, 4, t);
        cpu_write(2'd2, 5, t);
        cpu_write(2'd0, 3, t);
        count_pulses(30, c);
        check(c == 0, "R3 no pulse waiting", c, 0);
        check(step_irq == 1'b0, "R3 no irq waiting", step_irq, 0);
        sync_pulse(t);
        wait_pulse(p1);
        check(p1 - t == 4, "R3 delay after sync", p1 - t, 4);
        cpu_write(2'd2, 0, t);
        wait_pulse(p2);
        check(p2 - p1 == 5, "R5 interval sync run", p2 - p1, 5);
        wait_pulse(p3);
        check(p3 - p2 == 1, "R9 zero interval", p3 - p2, 1);
        cpu_write(2'd0, 0, t);
        count_pulses(10, c);
        check(c == 0, "R8 off in sync mode", c, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_free_run();
        test_disable_restart();
        test_sync_mode();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule